// File: doc/BRIEF.md
# Maskable Priority Interrupt Controller

This block gathers interrupt requests from up to sixteen sources and holds each one in a pending latch. A mask register gates the latches, and a fixed priority encoder picks the lowest-numbered unblocked source. The block raises a single request line to the processor and offers a vector address. The vector is a programmable base plus the winning source number scaled by four, so table entries sit four bytes apart.

When the processor accepts the interrupt, the block does three things at once. It copies the winner's own mask word into the mask register, pushes the previous mask onto a four-entry stack and clears the winner's pending latch. While that routine runs, only the sources its mask word leaves open can nest. Software can therefore reorder the effective nesting priority without changing the fixed hardware order.

An end-of-service strobe pops the saved mask back into the mask register. A simple write port programs the per-source mask words, the vector base and the mask register itself.

Top module: `mask_prio_intc`

## Requirements
- R1: After reset `int_req` is 0, `mask_q` is all zeros (every source enabled), `stack_err` is 0, and all pending latches, mask words and the base are 0.
- R2: A 1 on `irq_src[i]` during one clock sets pending bit i. The bit stays set after the input returns to 0, and it is cleared when source i is acknowledged.
- R3: Among pending, unmasked sources, the lowest index wins (source 0 highest). Once the winner is acknowledged, the next lowest pending one is presented.
- R4: `int_vec` equals (base + 4 × winning index) modulo 2^16.
- R5: Mask bit i = 1 blocks source i; `int_req` is 1 exactly when some pending source has its mask bit at 0.
- R6: On acknowledge (`int_ack`=1 while `int_req`=1), `mask_q` takes the mask word of the winning source on the next clock.
- R7: Each acknowledge pushes the old mask onto a 4-entry stack. Each `eoi` strobe with a non-empty stack pops the newest entry into `mask_q`, so nested service unwinds in reverse order.
- R8: An acknowledge while the stack already holds 4 entries pushes nothing and sets `stack_err`, which stays 1 until reset. The mask word is still loaded.
- R9: `eoi` with an empty stack leaves `mask_q` unchanged.
- R10: `int_ack` while `int_req` is 0 changes neither `mask_q` nor the stack.
- R11: A request raised while its source is masked stays pending and is presented once the mask bit is cleared.
- R12: The write port decodes `cfg_addr`: 0..15 is the mask word of that source, 16 is the vector base and 17 is the mask register. A mask-register write takes effect only in a cycle with no `int_ack` and no `eoi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 16 | Request inputs, one per source, sampled each clock |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| int_ack | input | 1 | Processor acknowledge of the presented interrupt |
| eoi | input | 1 | End-of-service strobe, restores the saved mask |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | 16 | Vector address of the presented source |
| mask_q | output | 16 | Current mask register |
| stack_err | output | 1 | Sticky mask-stack overflow flag |

## Verification
The assertions assume that `int_ack` and `eoi` are single-cycle strobes sampled on the rising clock, and that the processor takes no action on `int_vec` unless `int_req` is 1. They also assume that a source re-raising its request in the cycle it is acknowledged is legal and simply re-sets its latch. The stimulus drives every input on the falling edge and holds each strobe for one cycle. It acknowledges only after a request has been observed, except in the single case that checks an ignored acknowledge. Mask words are chosen so that each nesting step admits exactly the next intended source.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Index of the lowest set bit; 0 when no bit is set.
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Base plus source number scaled by the entry spacing.
  function automatic logic [31:0] vec_addr(input logic [31:0] base,
                                           input logic [31:0] idx,
                                           input int unsigned sh);
    return base + (idx << sh);
  endfunction
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NSRC  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  raise,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NSRC-1:0]  pend
);
  logic [NSRC-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | raise;
  end
endmodule

// File: rtl/intc_select.sv
module intc_select #(
  parameter int NSRC  = 16,
  parameter int IDX_W = 4,
  parameter int AW    = 16,
  parameter int SH    = 2
) (
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  mask,
  input  logic [AW-1:0]    base,
  output logic             req,
  output logic [IDX_W-1:0] win_idx,
  output logic [AW-1:0]    vec
);
  logic [NSRC-1:0] elig;
  logic [31:0]     elig32;
  logic [31:0]     vec32;

  assign elig    = pend & ~mask;
  assign elig32  = 32'(elig);
  assign req     = |elig;
  assign win_idx = IDX_W'(intc_pkg::lowest_set(elig32));
  assign vec32   = intc_pkg::vec_addr(32'(base), 32'(win_idx), SH);
  assign vec     = vec32[AW-1:0];
endmodule

// File: rtl/intc_mask_stack.sv
module intc_mask_stack #(
  parameter int NSRC  = 16,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [NSRC-1:0] new_mask,
  input  logic            pop_req,
  input  logic            sw_we,
  input  logic [NSRC-1:0] sw_val,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] top,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic            pop_fire,
  output logic            ovf_err
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NSRC-1:0]  stk [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign wr_ptr   = PTR_W'(cnt);
  assign rd_ptr   = PTR_W'(cnt - 1'b1);
  assign pop_fire = pop_req && !push && (cnt != '0);
  assign top      = (cnt != '0) ? stk[rd_ptr] : mask;
  assign depth    = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask    <= '0;
      cnt     <= '0;
      ovf_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      mask <= new_mask;
      if (full) begin
        ovf_err <= 1'b1;
      end else begin
        stk[wr_ptr] <= mask;
        cnt         <= cnt + 1'b1;
      end
    end else if (pop_req) begin
      if (cnt != '0) begin
        mask <= stk[rd_ptr];
        cnt  <= cnt - 1'b1;
      end
    end else if (sw_we) begin
      mask <= sw_val;
    end
  end
endmodule

// File: rtl/mask_prio_intc.sv
module mask_prio_intc #(
  parameter int NSRC        = 16,
  parameter int AW          = 16,
  parameter int STACK_DEPTH = 4,
  parameter int VEC_SHIFT   = 2,
  parameter int CFG_AW      = $clog2(NSRC + 2),
  parameter int DW          = (NSRC > AW) ? NSRC : AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              int_ack,
  input  logic              eoi,
  output logic              int_req,
  output logic [AW-1:0]     int_vec,
  output logic [NSRC-1:0]   mask_q,
  output logic              stack_err
);
  localparam int IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CNT_W     = $clog2(STACK_DEPTH + 1);
  localparam int BASE_ADDR = NSRC;
  localparam int MASK_ADDR = NSRC + 1;

  logic [NSRC-1:0]  mword [NSRC];
  logic [AW-1:0]    base_q;
  logic [NSRC-1:0]  pend;
  logic [IDX_W-1:0] win_idx;
  logic             ack_fire;
  logic             pop_fire;
  logic [NSRC-1:0]  word_sel;
  logic [NSRC-1:0]  stack_top;
  logic [CNT_W-1:0] depth;
  logic             mask_wr;

  assign ack_fire = int_ack && int_req;
  assign word_sel = mword[win_idx];
  assign mask_wr  = cfg_we && (cfg_addr == CFG_AW'(MASK_ADDR)) && !int_ack && !eoi;

  // Configuration storage: one mask word per source, plus the vector base.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      for (int i = 0; i < NSRC; i++) mword[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(BASE_ADDR)) base_q <= cfg_wdata[AW-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_addr == CFG_AW'(i)) mword[i] <= cfg_wdata[NSRC-1:0];
      end
    end
  end

  intc_pending #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .raise(irq_src),
    .clr_en(ack_fire), .clr_idx(win_idx), .pend(pend)
  );

  intc_select #(.NSRC(NSRC), .IDX_W(IDX_W), .AW(AW), .SH(VEC_SHIFT)) u_sel (
    .pend(pend), .mask(mask_q), .base(base_q),
    .req(int_req), .win_idx(win_idx), .vec(int_vec)
  );

  intc_mask_stack #(.NSRC(NSRC), .DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(ack_fire), .new_mask(word_sel),
    .pop_req(eoi), .sw_we(mask_wr), .sw_val(cfg_wdata[NSRC-1:0]),
    .mask(mask_q), .top(stack_top), .depth(depth),
    .pop_fire(pop_fire), .ovf_err(stack_err)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NSRC  = 16,
  parameter int IDX_W = 4,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  irq_src,
  input logic             int_req,
  input logic [NSRC-1:0]  mask_q,
  input logic             stack_err,
  input logic             ack_fire,
  input logic             pop_fire,
  input logic [IDX_W-1:0] win_idx,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  word_sel,
  input logic [NSRC-1:0]  stack_top,
  input logic [CNT_W-1:0] depth
);
  logic [NSRC-1:0] below_win;
  always_comb begin
    below_win = '0;
    for (int i = 0; i < NSRC; i++) below_win[i] = (i < int'(win_idx));
  end

  assert_winner_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (pend[win_idx] && !mask_q[win_idx]));

  assert_winner_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((pend & ~mask_q & below_win) == '0));

  assert_ack_loads_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (mask_q == $past(word_sel)));

  assert_ack_clears_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !irq_src[win_idx]) |=> !pend[$past(win_idx)]);

  assert_pop_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (mask_q == $past(stack_top)));

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  assert_overflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && depth == CNT_W'(DEPTH)) |=> stack_err);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);
endmodule

bind mask_prio_intc intc_checker #(
  .NSRC(NSRC), .IDX_W(IDX_W), .DEPTH(STACK_DEPTH), .CNT_W(CNT_W)
) u_intc_chk (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .int_req(int_req),
  .mask_q(mask_q), .stack_err(stack_err), .ack_fire(ack_fire),
  .pop_fire(pop_fire), .win_idx(win_idx), .pend(pend),
  .word_sel(word_sel), .stack_top(stack_top), .depth(depth)
);

// File: tb/mask_prio_intc_bench.sv
module mask_prio_intc_bench;
  localparam int PERIOD = 10;
  localparam int N      = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_src = '0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          int_ack = 1'b0;
  logic          eoi = 1'b0;
  logic          int_req;
  logic [15:0]   int_vec;
  logic [N-1:0]  mask_q;
  logic          stack_err;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  mask_prio_intc u_mask_prio_intc (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .int_ack(int_ack), .eoi(eoi),
    .int_req(int_req), .int_vec(int_vec), .mask_q(mask_q), .stack_err(stack_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk); irq_src = v;
    @(negedge clk); irq_src = '0;
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic end_svc();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] b, w, m_k;
    do_reset();
    // R1: reset state
    chk("R1 int_req", 32'(int_req), 0);
    chk("R1 mask_q", 32'(mask_q), 0);
    chk("R1 stack_err", 32'(stack_err), 0);

    // R2 R4 R6 R7 R12: each source alone, different bases (some wrap)
    for (int i = 0; i < N; i++) begin
      do_reset();
      b = 16'hFFC0 + 16'(i) * 16'h1111;
      w = 16'hA5A5 ^ 16'(i);
      wr(16, b);
      wr(i, w);
      pulse(N'(1) << i);
      chk("R2 latched request", 32'(int_req), 1);
      chk("R4 vector", 32'(int_vec), 32'(16'(b + 16'(i * 4))));
      ack();
      chk("R6 mask word loaded", 32'(mask_q), 32'(w));
      chk("R2 pending cleared", 32'(int_req), 0);
      end_svc();
      chk("R7 mask restored", 32'(mask_q), 0);
    end

    // R3: every pair of sources, lower index wins, then the other
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        do_reset();
        pulse((N'(1) << i) | (N'(1) << j));
        chk("R3 first winner", 32'(int_vec), 32'(i * 4));
        ack();
        chk("R3 second request", 32'(int_req), 1);
        chk("R3 second winner", 32'(int_vec), 32'(j * 4));
      end
    end

    // R5 R11 R12: masked request stays pending, appears once unmasked
    for (int i = 0; i < N; i++) begin
      do_reset();
      wr(N + 1, 16'(1) << i);
      chk("R12 mask register write", 32'(mask_q), 32'(16'(1) << i));
      pulse(N'(1) << i);
      chk("R5 masked source blocked", 32'(int_req), 0);
      wr(N + 1, 16'h0000);
      chk("R11 request after unmask", 32'(int_req), 1);
      chk("R11 vector after unmask", 32'(int_vec), 32'(i * 4));
    end

    // R7: nested service 5 -> 3 -> 1 -> 0; word k blocks sources k and above
    do_reset();
    for (int k = 0; k < 6; k++) wr(k, 16'hFFFF << k);
    pulse(N'(1) << 5); ack();
    chk("R7 nest level 1", 32'(mask_q), 32'(16'hFFE0));
    pulse(N'(1) << 3); ack();
    chk("R7 nest level 2", 32'(mask_q), 32'(16'hFFF8));
    pulse(N'(1) << 1); ack();
    chk("R7 nest level 3", 32'(mask_q), 32'(16'hFFFE));
    pulse(N'(1) << 0); ack();
    chk("R7 nest level 4", 32'(mask_q), 32'(16'hFFFF));
    chk("R7 no error at depth 4", 32'(stack_err), 0);
    end_svc(); chk("R7 unwind 1", 32'(mask_q), 32'(16'hFFFE));
    end_svc(); chk("R7 unwind 2", 32'(mask_q), 32'(16'hFFF8));
    end_svc(); chk("R7 unwind 3", 32'(mask_q), 32'(16'hFFE0));
    end_svc(); chk("R7 unwind 4", 32'(mask_q), 32'(16'h0000));

    // R9: eoi on an empty stack; R10: ack with no request
    do_reset();
    wr(N + 1, 16'h00F0);
    end_svc();
    chk("R9 empty pop ignored", 32'(mask_q), 32'(16'h00F0));
    ack();
    chk("R10 stray ack ignored", 32'(mask_q), 32'(16'h00F0));
    end_svc();
    chk("R10 nothing pushed", 32'(mask_q), 32'(16'h00F0));

    // R8: fifth nested acknowledge overflows
    do_reset();
    wr(7, 16'h0001);
    for (int n = 1; n <= 5; n++) begin
      pulse(N'(1) << 7); ack();
      if (n == 4) chk("R8 no overflow at 4", 32'(stack_err), 0);
    end
    chk("R8 overflow flagged", 32'(stack_err), 1);
    chk("R8 word still loaded", 32'(mask_q), 32'(16'h0001));
    m_k = 16'h0001;
    for (int n = 1; n <= 4; n++) begin
      end_svc();
      if (n == 4) m_k = 16'h0000;
      chk("R8 unwind after overflow", 32'(mask_q), 32'(m_k));
    end
    chk("R8 flag sticky", 32'(stack_err), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule